// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Generator

This block splits every instruction cycle of a small processor core into four consecutive input clock periods, called Q1, Q2, Q3 and Q4. It gives them out as a one-hot phase vector. Beside the vector it drives the timing enables that the rest of the core uses:

- a program counter step in Q1;
- a data memory operand read in Q2;
- a data memory destination write in Q4;
- an instruction register load in Q4.

The instruction loaded in Q4 is then decoded and executed over the next four phases.

All outputs are enables of one input clock period, and all of them come straight from flops. No output is a derived clock net. A square wave at one quarter of the input frequency is also driven out, so that logic outside the core can see the instruction rate. It is high for the first half of each cycle.

The reset input is active low and asynchronous. It holds every output low. Once reset is released, the first rising clock edge starts a fresh cycle at Q1.

Top module: `quad_cycle_gen`

## Requirements
- R1: While `rst_n` is low, `phase`, `pcInc`, `memRead`, `memWrite`, `irLoad` and `clkOut` are all low.
- R2: On the first rising clock edge with `rst_n` high, `phase` becomes 4'b0001 (Q1). Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4.
- R3: After that first edge and until the next reset, exactly one bit of `phase` is high in every clock period.
- R4: Phases advance one per rising clock edge in the order Q1, Q2, Q3, Q4, then back to Q1.
- R5: `pcInc` is high exactly in the periods where Q1 is active.
- R6: `memRead` is high exactly in the periods where Q2 is active.
- R7: `memWrite` is high exactly in the periods where Q4 is active.
- R8: `irLoad` is high exactly in the periods where Q4 is active.
- R9: `clkOut` is high during Q1 and Q2 and low during Q3 and Q4. This gives a period of four input clocks and a 50% duty cycle, with its rising edge aligned to the start of Q1.
- R10: A reset asserted in the middle of an instruction cycle abandons that cycle at once. After release, counting starts again at Q1, whatever phase was active before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, four periods per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | output | 4 | One-hot phase vector; bit 0 = Q1 through bit 3 = Q4 |
| pcInc | output | 1 | Program counter step enable (Q1) |
| memRead | output | 1 | Data memory operand read enable (Q2) |
| memWrite | output | 1 | Data memory destination write enable (Q4) |
| irLoad | output | 1 | Instruction register load enable (Q4) |
| clkOut | output | 1 | Instruction-rate square wave, high in Q1 and Q2 |

## Verification
A wrong phase index shows at the ports within one clock period. Every output is decoded from that index, so one bad value moves the one-hot bit, the enables and the half of `clkOut` together in the same cycle. A counter stuck on one value, or one that skips a value, breaks the order of `phase` by the next edge. A counter that wraps at the wrong count makes the `clkOut` period something other than four clocks. A restart at a phase other than Q1 is visible on the very first edge after reset is released. The bench therefore compares every output in every period, and places resets both at the end of a cycle and in its middle.

// File: rtl/qcyc_pkg.sv
package qcyc_pkg;
  // Number of phases in one instruction cycle and the width of their index.
  localparam int NUM_PHASES = 4;
  localparam int IDX_W      = $clog2(NUM_PHASES);

  // Phase index (0 = Q1) that owns each pipeline enable.
  localparam int PH_PC_STEP = 0;
  localparam int PH_MEM_RD  = 1;
  localparam int PH_MEM_WR  = 3;
  localparam int PH_IR_LOAD = 3;

  // Number of leading phases during which the rate output is high.
  localparam int CLK_HIGH_PHASES = NUM_PHASES / 2;

  // Strobe bundle passed from the control to the datapath.
  typedef struct packed {
    logic [IDX_W-1:0] nextIdx;   // phase index to present after the coming edge
    logic             clkNext;   // rate output value after the coming edge
  } phaseStrobe_t;
endpackage

// File: rtl/qcyc_ctrl.sv
module qcyc_ctrl
  import qcyc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  output phaseStrobe_t strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PHASES - 1);

  logic             running;
  logic [IDX_W-1:0] curIdx;

  // Sequence the phase index. The first edge out of reset goes to index 0.
  always_comb begin
    if (!running)
      strobe.nextIdx = '0;
    else if (curIdx == LAST_IDX)
      strobe.nextIdx = '0;
    else
      strobe.nextIdx = curIdx + 1'b1;
    strobe.clkNext = (int'(strobe.nextIdx) < CLK_HIGH_PHASES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      curIdx  <= '0;
    end else begin
      running <= 1'b1;
      curIdx  <= strobe.nextIdx;
    end
  end
endmodule

// File: rtl/qcyc_datapath.sv
module qcyc_datapath
  import qcyc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  phaseStrobe_t          strobe,
  output logic [NUM_PHASES-1:0] phaseQ,
  output logic                  pcIncQ,
  output logic                  memReadQ,
  output logic                  memWriteQ,
  output logic                  irLoadQ,
  output logic                  clkOutQ
);
  // One flop per phase bit, each loaded from a decode of the next index.
  for (genvar g = 0; g < NUM_PHASES; g++) begin : gPhase
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phaseQ[g] <= 1'b0;
      else        phaseQ[g] <= (strobe.nextIdx == IDX_W'(g));
    end
  end

  // Enables and the rate output also come straight from flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcIncQ    <= 1'b0;
      memReadQ  <= 1'b0;
      memWriteQ <= 1'b0;
      irLoadQ   <= 1'b0;
      clkOutQ   <= 1'b0;
    end else begin
      pcIncQ    <= (strobe.nextIdx == IDX_W'(PH_PC_STEP));
      memReadQ  <= (strobe.nextIdx == IDX_W'(PH_MEM_RD));
      memWriteQ <= (strobe.nextIdx == IDX_W'(PH_MEM_WR));
      irLoadQ   <= (strobe.nextIdx == IDX_W'(PH_IR_LOAD));
      clkOutQ   <= strobe.clkNext;
    end
  end
endmodule

// File: rtl/quad_cycle_gen.sv
module quad_cycle_gen
  import qcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] phase,
  output logic       pcInc,
  output logic       memRead,
  output logic       memWrite,
  output logic       irLoad,
  output logic       clkOut
);
  phaseStrobe_t strobe;

  qcyc_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe)
  );

  qcyc_datapath i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .phaseQ    (phase),
    .pcIncQ    (pcInc),
    .memReadQ  (memRead),
    .memWriteQ (memWrite),
    .irLoadQ   (irLoad),
    .clkOutQ   (clkOut)
  );
endmodule

// File: rtl/qcyc_checker.sv
module qcyc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] phase,
  input logic       pcInc,
  input logic       memRead,
  input logic       memWrite,
  input logic       irLoad,
  input logic       clkOut
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (phase == 4'b0000 && !pcInc && !memRead && !memWrite && !irLoad && !clkOut));

  assert_start_q1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> (phase == 4'b0001));

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $onehot(phase));

  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(phase) != 4'b0000) |-> (phase == {$past(phase[2:0]), $past(phase[3])}));

  assert_pc_then_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pcInc |=> (memRead && !pcInc));

  assert_read_then_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memRead |-> ##2 memWrite);

  assert_write_then_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    memWrite |=> (pcInc && !memWrite));

  assert_irload_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irLoad) |-> memWrite);

  assert_clkout_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkOut) |-> (pcInc ##1 clkOut ##1 !clkOut ##1 !clkOut));

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> (pcInc && clkOut));
endmodule

bind quad_cycle_gen qcyc_checker i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase),
  .pcInc    (pcInc),
  .memRead  (memRead),
  .memWrite (memWrite),
  .irLoad   (irLoad),
  .clkOut   (clkOut)
);

// File: tb/test_quad_cycle_gen.sv
module test_quad_cycle_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] phase;
  logic       pcInc, memRead, memWrite, irLoad, clkOut;

  int checks   = 0;
  int failures = 0;
  int edgesSinceRelease = 0;  // rising edges seen with reset released
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  quad_cycle_gen i_quad_cycle_gen (
    .clk(clk), .rst_n(rst_n), .phase(phase), .pcInc(pcInc),
    .memRead(memRead), .memWrite(memWrite), .irLoad(irLoad), .clkOut(clkOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: count edges after release, phase index = (n-1) mod 4.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edgesSinceRelease <= 0;
    else        edgesSinceRelease <= edgesSinceRelease + 1;
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst_n || edgesSinceRelease == 0) begin
      check("R1", "phase", int'(phase), 0);
      check("R1", "enables", int'({pcInc, memRead, memWrite, irLoad, clkOut}), 0);
    end else begin
      int idx;
      idx = (edgesSinceRelease - 1) % 4;
      if (edgesSinceRelease == 1) check("R2", "first phase", int'(phase), 1);
      check("R3", "one-hot count", $countones(phase), 1);
      check("R4", "phase order", int'(phase), 1 << idx);
      check("R5", "pcInc", int'(pcInc), int'(idx == 0));
      check("R6", "memRead", int'(memRead), int'(idx == 1));
      check("R7", "memWrite", int'(memWrite), int'(idx == 3));
      check("R8", "irLoad", int'(irLoad), int'(idx == 3));
      check("R9", "clkOut", int'(clkOut), int'(idx < 2));
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    waitCycles(5);
    rst_n = 1'b1;
    waitCycles(41);             // run, stopping inside Q1 of a cycle
    #3 rst_n = 1'b0;            // R10: reset in the middle of a cycle
    waitCycles(3);
    rst_n = 1'b1;
    waitCycles(30);
    #5 rst_n = 1'b0;            // R10: reset again at a later phase
    waitCycles(1);
    rst_n = 1'b1;
    waitCycles(2);              // R10: restart seen after a short reset
    #5 rst_n = 1'b0;
    waitCycles(2);
    rst_n = 1'b1;
    waitCycles(25);
    done = 1'b1;
  end

  initial begin
    wait (done || cycles > 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule